// File: doc/BRIEF.md
# Serial Byte Link with Hardware Flow Control

This block sends and receives asynchronous serial characters. Bytes that the host pushes go into a transmit FIFO. A transmit shifter sends each byte as a start bit, the data bits (least significant first), an optional even parity bit and the stop bits. A receiver with 16x oversampling rebuilds incoming characters and stores each one, together with its parity result, in a receive FIFO. The host reads that FIFO through a valid/ready stream.

Framing is set by static configuration inputs: the oversampling tick period, the data width (1 to 8 bits), the stop-bit count (0 to 15), parity enable, flow-control enable and loopback. With flow control on, the clear-to-send output is active low. It holds the remote sender off while the receive FIFO is full. The incoming request-to-send line pauses transmission after a programmable number of further bytes.

Top module: `uart_fc_top`

## Requirements
- R1: An idle `line_tx` is 1. A transmitted character is one 0 start bit, then `cfg_data_bits` data bits with the least significant bit first, then the parity bit if enabled, then `cfg_stop_bits` stop bits of value 1. Each bit lasts 16*`cfg_div` clock cycles.
- R2: Received characters are popped in arrival order. `rx_valid` stays high and `rx_data` stays stable until the cycle in which `rx_ready` is high.
- R3: With `cfg_data_bits` = n (1..8), only n bits go out on the line. In a received byte, bits n..7 read as 0.
- R4: `cfg_stop_bits` may be 0. In that case the next start bit can follow the last data or parity bit directly, and both the transmitter and the receiver handle such back-to-back characters.
- R5: Parity is even. The transmitted parity bit is the XOR of the data bits. `rx_par_ok` is 1 when the received data bits and the parity bit together hold an even number of ones. A mismatch sets `par_err`, which stays set until `par_err_clr` is pulsed.
- R6: `cts_n` is 0 while `cfg_flow_en` is 0. When `cfg_flow_en` is 1, `cts_n` is 1 exactly while the receive FIFO holds RX_DEPTH bytes. A character that completes while the FIFO is full is discarded.
- R7: With `cfg_loop` = 1, `line_tx` follows `line_rx` at once, and the received characters are still stored.
- R8: With `cfg_flow_en` = 1 and `rts_n` = 1, at most `cfg_tx_grace` more characters start. The allowance reloads while `rts_n` is 0. With an allowance of 0, nothing starts.
- R9: `tx_empty` is 1 only while the transmit FIFO is empty and the last stop bit of the current character has ended.
- R10: `rx_valid` rises no more than half a bit after the middle of the last stop bit, plus a few cycles of synchronisation.
- R11: `tx_ready` is 0 while the transmit FIFO holds TX_DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick (1 or more) |
| cfg_data_bits | input | 4 | Data bits per character, 1..8 |
| cfg_stop_bits | input | CNT_W | Stop bits per character, 0 or more |
| cfg_par_en | input | 1 | Even parity enable |
| cfg_flow_en | input | 1 | Flow control enable |
| cfg_loop | input | 1 | Mirror line_rx onto line_tx |
| cfg_tx_grace | input | CNT_W | Characters allowed after rts_n rises |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Push request |
| tx_ready | output | 1 | Transmit FIFO has room |
| rx_data | output | 8 | Oldest received byte |
| rx_par_ok | output | 1 | Parity result of rx_data |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Pop request |
| tx_empty | output | 1 | Nothing queued or in flight |
| par_err | output | 1 | Sticky parity error |
| par_err_clr | input | 1 | Clears par_err |
| line_tx | output | 1 | Serial output |
| line_rx | input | 1 | Serial input |
| cts_n | output | 1 | Clear to send, active low |
| rts_n | input | 1 | Remote stop request, 1 = stop |

## Verification
A bit or stop counter that has slipped shows as a misframed character. On the receive side, this is a wrong byte on the next pop. On the transmit side, the bench's line decoder sees a wrong value or a stop bit at 0 within one character time. A wrong send allowance shows as too many or too few characters on `line_tx` during the first few frame times after `rts_n` rises. A FIFO pointer error shows as reordered, duplicated or lost bytes, or as a wrong `cts_n` level, at the very next pop.

// File: rtl/uart_fc_pkg.sv
// Shared constants, state encoding and the receive word type.
package uart_fc_pkg;
    localparam int OVS    = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        LS_IDLE, LS_START, LS_DATA, LS_PAR, LS_STOP, LS_TAIL
    } line_st_t;

    typedef struct packed {
        logic              par_ok;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

    // Mask with the lowest n bits set (n in 1..8).
    function automatic logic [BYTE_W-1:0] bits_mask(input logic [3:0] n);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction
endpackage

// File: rtl/uart_fc_fifo.sv
// Small synchronous FIFO. Pushes when full and pops when empty are ignored.
// Assumes that one read and one write per cycle are allowed.
module uart_fc_fifo #(
    parameter  int W     = 8,
    parameter  int DEPTH = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_fc_tx.sv
// Transmit shifter. It sends start, data (LSB first), optional even parity and
// stop bits, each lasting 16 oversampling ticks. Assumes that start is only
// acted upon while the shifter is idle.
module uart_fc_tx
    import uart_fc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] din,
    input  logic [3:0]        data_bits,
    input  logic [CNT_W-1:0]  stop_bits,
    input  logic              par_en,
    output logic              txd,
    output logic              busy
);
    line_st_t          st;
    logic [3:0]        sub;
    logic [2:0]        idx;
    logic [CNT_W-1:0]  scnt;
    logic [BYTE_W-1:0] shreg;
    logic              parbit;
    logic              last_bit;

    assign busy     = (st != LS_IDLE);
    assign last_bit = ({1'b0, idx} == data_bits - 4'd1);

    // Frame sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= LS_IDLE;
            sub    <= '0;
            idx    <= '0;
            scnt   <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
        end else if (st == LS_IDLE) begin
            if (start) begin
                shreg  <= din & bits_mask(data_bits);
                parbit <= ^(din & bits_mask(data_bits));
                sub    <= '0;
                idx    <= '0;
                st     <= LS_START;
            end
        end else if (tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'd15) begin
                case (st)
                    LS_START: st <= LS_DATA;
                    LS_DATA: begin
                        if (!last_bit)          idx <= idx + 3'd1;
                        else if (par_en)        st  <= LS_PAR;
                        else if (stop_bits != 0) begin st <= LS_STOP; scnt <= '0; end
                        else                    st  <= LS_IDLE;
                    end
                    LS_PAR: begin
                        if (stop_bits != 0) begin st <= LS_STOP; scnt <= '0; end
                        else st <= LS_IDLE;
                    end
                    LS_STOP: begin
                        if (scnt == stop_bits - 1'b1) st <= LS_IDLE;
                        else scnt <= scnt + 1'b1;
                    end
                    default: st <= LS_IDLE;
                endcase
            end
        end
    end

    // Line level for the current bit.
    always_comb begin
        case (st)
            LS_START: txd = 1'b0;
            LS_DATA:  txd = shreg[idx];
            LS_PAR:   txd = parbit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_fc_rx.sv
// Receiver with 16x oversampling. It qualifies the start bit at mid-bit,
// then samples every later bit at mid-bit. It pulses done right after the
// last stop sample. With zero stop bits it waits out the final half bit
// before it looks for a new start bit. Assumes that rxd is already synchronised.
module uart_fc_rx
    import uart_fc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [3:0]        data_bits,
    input  logic [CNT_W-1:0]  stop_bits,
    input  logic              par_en,
    output logic              done,
    output logic [BYTE_W-1:0] data,
    output logic              par_ok
);
    line_st_t          st;
    logic [3:0]        sub;
    logic [2:0]        idx;
    logic [CNT_W-1:0]  scnt;
    logic [BYTE_W-1:0] shreg;
    logic              parbit;
    logic              last_bit;

    assign last_bit = ({1'b0, idx} == data_bits - 4'd1);
    assign data     = shreg;
    assign par_ok   = !par_en || !(^shreg ^ parbit);

    // Frame reception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= LS_IDLE;
            sub    <= '0;
            idx    <= '0;
            scnt   <= '0;
            shreg  <= '0;
            parbit <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == LS_IDLE) begin
                if (!rxd) begin
                    st  <= LS_START;
                    sub <= '0;
                end
            end else if (tick) begin
                sub <= sub + 4'd1;
                case (st)
                    LS_START: if (sub == 4'd7) begin
                        sub <= '0;
                        if (!rxd) begin
                            st     <= LS_DATA;
                            idx    <= '0;
                            shreg  <= '0;
                            parbit <= 1'b0;
                        end else st <= LS_IDLE;
                    end
                    LS_DATA: if (sub == 4'd15) begin
                        shreg[idx] <= rxd;
                        if (!last_bit)           idx <= idx + 3'd1;
                        else if (par_en)         st  <= LS_PAR;
                        else if (stop_bits != 0) begin st <= LS_STOP; scnt <= '0; end
                        else begin done <= 1'b1; st <= LS_TAIL; end
                    end
                    LS_PAR: if (sub == 4'd15) begin
                        parbit <= rxd;
                        if (stop_bits != 0) begin st <= LS_STOP; scnt <= '0; end
                        else begin done <= 1'b1; st <= LS_TAIL; end
                    end
                    LS_STOP: if (sub == 4'd15) begin
                        if (scnt == stop_bits - 1'b1) begin
                            done <= 1'b1;
                            st   <= LS_IDLE;
                        end else scnt <= scnt + 1'b1;
                    end
                    LS_TAIL: if (sub == 4'd7) st <= LS_IDLE;
                    default: st <= LS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_fc_top.sv
// Serial byte link top. Holds the oversampling tick generator, the line
// synchronisers, both FIFOs, the send allowance that applies after rts_n
// rises, clear-to-send generation and loopback. Assumes static configuration
// while traffic is in flight, and cfg_div >= 1.
module uart_fc_top
    import uart_fc_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int TX_DEPTH = 4,
    parameter int DIV_W    = 16,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [3:0]        cfg_data_bits,
    input  logic [CNT_W-1:0]  cfg_stop_bits,
    input  logic              cfg_par_en,
    input  logic              cfg_flow_en,
    input  logic              cfg_loop,
    input  logic [CNT_W-1:0]  cfg_tx_grace,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_par_ok,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              tx_empty,
    output logic              par_err,
    input  logic              par_err_clr,
    output logic              line_tx,
    input  logic              line_rx,
    output logic              cts_n,
    input  logic              rts_n
);
    localparam int RX_CW = $clog2(RX_DEPTH + 1);
    localparam int TX_CW = $clog2(TX_DEPTH + 1);

    logic [DIV_W-1:0]  div_cnt;
    logic              tick;
    logic [1:0]        rx_sync, rts_sync;
    logic              rx_s, rts_s;
    logic [CNT_W-1:0]  credit;
    logic              send_ok, tx_start, tx_busy, txd;
    logic              tx_full, tx_fifo_empty;
    logic [BYTE_W-1:0] tx_head;
    logic [TX_CW-1:0]  tx_count;
    logic              rx_done, rx_full, rx_empty, rx_bit_ok;
    logic [BYTE_W-1:0] rx_byte;
    logic [RX_CW-1:0]  rx_count;
    rx_word_t          rx_in, rx_out;

    assign tick = (div_cnt == cfg_div - 1'b1);

    // Oversampling tick divider.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    // Two-stage synchronisers for the incoming line and rts_n.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sync  <= 2'b11;
            rts_sync <= 2'b00;
        end else begin
            rx_sync  <= {rx_sync[0], line_rx};
            rts_sync <= {rts_sync[0], rts_n};
        end
    end
    assign rx_s  = rx_sync[1];
    assign rts_s = rts_sync[1];

    // Send allowance: reloads while rts is low, spent per character while high.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       credit <= '0;
        else if (!rts_s)                                  credit <= cfg_tx_grace;
        else if (tx_start && cfg_flow_en && credit != 0)  credit <= credit - 1'b1;
    end

    assign send_ok  = !cfg_flow_en || !rts_s || (credit != 0);
    assign tx_start = !tx_busy && !tx_fifo_empty && send_ok;

    uart_fc_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_valid), .wdata(tx_data),
        .pop(tx_start), .rdata(tx_head), .full(tx_full),
        .empty(tx_fifo_empty), .count(tx_count)
    );

    uart_fc_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start), .din(tx_head),
        .data_bits(cfg_data_bits), .stop_bits(cfg_stop_bits),
        .par_en(cfg_par_en), .txd(txd), .busy(tx_busy)
    );

    uart_fc_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rx_s),
        .data_bits(cfg_data_bits), .stop_bits(cfg_stop_bits),
        .par_en(cfg_par_en), .done(rx_done), .data(rx_byte), .par_ok(rx_bit_ok)
    );

    assign rx_in = '{par_ok: rx_bit_ok, data: rx_byte};

    uart_fc_fifo #(.W($bits(rx_word_t)), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_done), .wdata(rx_in),
        .pop(rx_ready), .rdata(rx_out), .full(rx_full),
        .empty(rx_empty), .count(rx_count)
    );

    // Sticky parity error; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    par_err <= 1'b0;
        else if (rx_done && !rx_bit_ok) par_err <= 1'b1;
        else if (par_err_clr)          par_err <= 1'b0;
    end

    assign tx_ready  = !tx_full;
    assign tx_empty  = tx_fifo_empty && !tx_busy && (tx_count == '0);
    assign rx_valid  = !rx_empty;
    assign rx_data   = rx_out.data;
    assign rx_par_ok = rx_out.par_ok;
    assign cts_n     = cfg_flow_en && rx_full;
    assign line_tx   = cfg_loop ? line_rx : txd;
endmodule

// File: rtl/uart_fc_chk.sv
// Protocol checker for uart_fc_top, attached through bind.
module uart_fc_chk #(
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_flow_en,
    input logic                         cfg_loop,
    input logic [3:0]                   cfg_data_bits,
    input logic                         rx_valid,
    input logic                         rx_ready,
    input logic [7:0]                   rx_data,
    input logic                         line_tx,
    input logic                         tx_empty,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_count,
    input logic                         rts_s,
    input logic [CNT_W-1:0]             credit,
    input logic                         tx_busy
);
    // R2
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

    // R3
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && cfg_data_bits >= 4'd1 && cfg_data_bits <= 4'd8
        |-> (rx_data >> cfg_data_bits) == 8'd0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= ($clog2(RX_DEPTH+1))'(RX_DEPTH));

    // R8
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_flow_en && rts_s && credit == '0 && !tx_busy |=> !tx_busy);

    // R9
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && !cfg_loop |-> line_tx);
endmodule

bind uart_fc_top uart_fc_chk #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_flow_en(cfg_flow_en), .cfg_loop(cfg_loop),
    .cfg_data_bits(cfg_data_bits), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .line_tx(line_tx), .tx_empty(tx_empty),
    .rx_count(rx_count), .rts_s(rts_s), .credit(credit), .tx_busy(tx_busy)
);

// File: tb/sim_uart_fc_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario; a background decoder watches line_tx.
module sim_uart_fc_top;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] cfg_div = 16'(DIV);
    logic [3:0] cfg_data_bits = 4'd8;
    logic [3:0] cfg_stop_bits = 4'd1;
    logic       cfg_par_en = 1'b0, cfg_flow_en = 1'b0, cfg_loop = 1'b0;
    logic [3:0] cfg_tx_grace = 4'd0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0, rx_ready = 1'b0, par_err_clr = 1'b0;
    logic       line_rx = 1'b1, rts_n = 1'b0;
    logic       tx_ready, rx_par_ok, rx_valid, tx_empty, par_err, line_tx, cts_n;
    logic [7:0] rx_data;

    int checks = 0, bad = 0, cyc = 0;
    int mon_cnt = 0, mon_stop_bad = 0, rx_rise = 0;
    logic [7:0] mon_byte [16];
    logic       mon_par  [16];
    int         mon_t    [16];

    always #2 clk = ~clk;

    uart_fc_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_data_bits(cfg_data_bits),
        .cfg_stop_bits(cfg_stop_bits), .cfg_par_en(cfg_par_en),
        .cfg_flow_en(cfg_flow_en), .cfg_loop(cfg_loop), .cfg_tx_grace(cfg_tx_grace),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_par_ok(rx_par_ok), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .par_err(par_err),
        .par_err_clr(par_err_clr), .line_tx(line_tx), .line_rx(line_rx),
        .cts_n(cts_n), .rts_n(rts_n)
    );

    initial forever begin @(posedge clk); cyc = cyc + 1; end

    // Records the cycle in which rx_valid rises.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rx_valid && !prev) rx_rise = cyc;
            prev = rx_valid;
        end
    end

    // Line decoder for line_tx using the current configuration.
    initial begin
        logic [7:0] b;
        logic p;
        int t;
        forever begin
            @(negedge clk);
            if (rst_n && line_tx == 1'b0) begin
                t = cyc;
                repeat (BIT/2) @(negedge clk);
                if (line_tx == 1'b0) begin
                    b = 8'h00; p = 1'b0;
                    for (int i = 0; i < int'(cfg_data_bits); i++) begin
                        repeat (BIT) @(negedge clk); b[i] = line_tx;
                    end
                    if (cfg_par_en) begin repeat (BIT) @(negedge clk); p = line_tx; end
                    for (int s = 0; s < int'(cfg_stop_bits); s++) begin
                        repeat (BIT) @(negedge clk);
                        if (!line_tx) mon_stop_bad = mon_stop_bad + 1;
                    end
                    if (mon_cnt < 16) begin
                        mon_byte[mon_cnt] = b; mon_par[mon_cnt] = p; mon_t[mon_cnt] = t;
                    end
                    mon_cnt = mon_cnt + 1;
                    if (cfg_stop_bits == 0) repeat (BIT/2) @(negedge clk);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks = checks + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp_v);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d, output logic pok, output logic v);
        @(negedge clk); v = rx_valid; d = rx_data; pok = rx_par_ok; rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    task automatic drive_frame(input logic [7:0] d, input int nb, input bit par,
                               input bit badp, input int ns);
        logic [7:0] m;
        m = 8'hFF >> (8 - nb);
        line_rx = 1'b0; repeat (BIT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin line_rx = d[i]; repeat (BIT) @(negedge clk); end
        if (par) begin line_rx = ^(d & m) ^ badp; repeat (BIT) @(negedge clk); end
        for (int s = 0; s < ns; s++) begin line_rx = 1'b1; repeat (BIT) @(negedge clk); end
    endtask

    task automatic idle(input int n);
        line_rx = 1'b1; repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(line_tx == 1'b1, "R1 idle line", line_tx, 1);
        chk(tx_empty == 1'b1, "R9 empty after reset", tx_empty, 1);
        chk(rx_valid == 1'b0, "R2 no rx after reset", rx_valid, 0);
        chk(cts_n == 1'b0, "R6 cts with flow off", cts_n, 0);
        chk(tx_ready == 1'b1, "R11 ready after reset", tx_ready, 1);
    endtask

    task automatic t_tx_basic;
        int p;
        mon_cnt = 0; mon_stop_bad = 0;
        push(8'hA5); p = cyc;
        while (cyc < p + 305) @(negedge clk);
        chk(tx_empty == 1'b0, "R9 busy in stop bit", tx_empty, 0);
        while (cyc < p + 335) @(negedge clk);
        chk(tx_empty == 1'b1, "R9 empty after stop", tx_empty, 1);
        push(8'h3C);
        repeat (400) @(negedge clk);
        chk(mon_cnt == 2, "R1 frame count", mon_cnt, 2);
        chk(mon_byte[0] == 8'hA5, "R1 first byte", mon_byte[0], 8'hA5);
        chk(mon_byte[1] == 8'h3C, "R1 second byte", mon_byte[1], 8'h3C);
        chk(mon_stop_bad == 0, "R1 stop level", mon_stop_bad, 0);
    endtask

    task automatic t_tx_narrow_parity;
        int gap;
        cfg_data_bits = 4'd5; cfg_par_en = 1'b1; cfg_stop_bits = 4'd2;
        mon_cnt = 0; mon_stop_bad = 0;
        push(8'h3B); push(8'h07);
        repeat (700) @(negedge clk);
        gap = mon_t[1] - mon_t[0];
        chk(mon_cnt == 2, "R3 narrow frames", mon_cnt, 2);
        chk(mon_byte[0] == 8'h1B, "R3 five bits sent", mon_byte[0], 8'h1B);
        chk(mon_par[0] == 1'b0, "R5 even parity of 0x1B", mon_par[0], 0);
        chk(mon_par[1] == 1'b1, "R5 even parity of 0x07", mon_par[1], 1);
        chk(gap >= 9*BIT-4 && gap <= 9*BIT+4, "R4 two stop bits spacing", gap, 9*BIT);
        chk(mon_stop_bad == 0, "R4 stop levels", mon_stop_bad, 0);
        cfg_data_bits = 4'd8; cfg_par_en = 1'b0; cfg_stop_bits = 4'd1;
    endtask

    task automatic t_tx_stop0;
        int gap;
        cfg_stop_bits = 4'd0;
        mon_cnt = 0;
        push(8'h5A); push(8'h81);
        repeat (700) @(negedge clk);
        gap = mon_t[1] - mon_t[0];
        chk(mon_cnt == 2 && mon_byte[0] == 8'h5A && mon_byte[1] == 8'h81,
            "R4 zero stop tx bytes", {mon_byte[0], mon_byte[1]}, 16'h5A81);
        chk(gap >= 9*BIT-4 && gap <= 9*BIT+4, "R4 zero stop spacing", gap, 9*BIT);
        cfg_stop_bits = 4'd1;
    endtask

    task automatic t_rx_basic;
        logic [7:0] d; logic pk, v; int t0;
        @(negedge clk); t0 = cyc;
        drive_frame(8'h96, 8, 0, 0, 1); idle(40);
        chk(rx_rise - t0 >= 300 && rx_rise - t0 <= 316, "R10 rx ready latency",
            rx_rise - t0, 308);
        pop(d, pk, v);
        chk(v && d == 8'h96, "R2 rx byte", d, 8'h96);
        drive_frame(8'h11, 8, 0, 0, 1); drive_frame(8'h22, 8, 0, 0, 1); idle(40);
        pop(d, pk, v);
        chk(v && d == 8'h11, "R2 order first", d, 8'h11);
        pop(d, pk, v);
        chk(v && d == 8'h22, "R2 order second", d, 8'h22);
        @(negedge clk);
        chk(rx_valid == 1'b0, "R2 drained", rx_valid, 0);
    endtask

    task automatic t_rx_narrow_stop0;
        logic [7:0] d; logic pk, v;
        cfg_data_bits = 4'd5; idle(5);
        drive_frame(8'hF5, 5, 0, 0, 1); idle(40);
        pop(d, pk, v);
        chk(v && d == 8'h15, "R3 rx upper bits zero", d, 8'h15);
        cfg_data_bits = 4'd8; cfg_stop_bits = 4'd0; idle(5);
        drive_frame(8'h12, 8, 0, 0, 0); drive_frame(8'h34, 8, 0, 0, 0); idle(60);
        pop(d, pk, v);
        chk(v && d == 8'h12, "R4 zero stop rx first", d, 8'h12);
        pop(d, pk, v);
        chk(v && d == 8'h34, "R4 zero stop rx second", d, 8'h34);
        cfg_stop_bits = 4'd1; idle(5);
    endtask

    task automatic t_rx_parity;
        logic [7:0] d; logic pk, v;
        cfg_par_en = 1'b1; idle(5);
        drive_frame(8'hC3, 8, 1, 0, 1); idle(40);
        chk(par_err == 1'b0, "R5 no error on good parity", par_err, 0);
        pop(d, pk, v);
        chk(v && d == 8'hC3 && pk, "R5 good parity flag", {pk, d}, 9'h1C3);
        drive_frame(8'h55, 8, 1, 1, 1); idle(40);
        pop(d, pk, v);
        chk(v && d == 8'h55 && !pk, "R5 bad parity flag", {pk, d}, 9'h055);
        @(negedge clk);
        chk(par_err == 1'b1, "R5 sticky error", par_err, 1);
        par_err_clr = 1'b1; @(negedge clk); par_err_clr = 1'b0; @(negedge clk);
        chk(par_err == 1'b0, "R5 error cleared", par_err, 0);
        cfg_par_en = 1'b0; idle(5);
    endtask

    task automatic t_cts;
        logic [7:0] d; logic pk, v;
        cfg_flow_en = 1'b1; idle(5);
        chk(cts_n == 1'b0, "R6 cts low when room", cts_n, 0);
        for (int i = 1; i <= 4; i++) begin drive_frame(8'(i), 8, 0, 0, 1); idle(20); end
        chk(cts_n == 1'b1, "R6 cts high when full", cts_n, 1);
        drive_frame(8'h99, 8, 0, 0, 1); idle(40);
        for (int i = 1; i <= 4; i++) begin
            pop(d, pk, v);
            chk(v && d == 8'(i), "R6 kept bytes", d, i);
        end
        @(negedge clk);
        chk(rx_valid == 1'b0, "R6 overflow byte dropped", rx_valid, 0);
        chk(cts_n == 1'b0, "R6 cts released", cts_n, 0);
        cfg_flow_en = 1'b0;
    endtask

    task automatic t_loop;
        logic [7:0] d; logic pk, v;
        cfg_loop = 1'b1; mon_cnt = 0;
        @(negedge clk); line_rx = 1'b0; #1;
        chk(line_tx == 1'b0, "R7 mirror low", line_tx, 0);
        line_rx = 1'b1; #1;
        chk(line_tx == 1'b1, "R7 mirror high", line_tx, 1);
        idle(5);
        drive_frame(8'h6E, 8, 0, 0, 1); idle(40);
        chk(mon_cnt == 1 && mon_byte[0] == 8'h6E, "R7 frame mirrored", mon_byte[0], 8'h6E);
        pop(d, pk, v);
        chk(v && d == 8'h6E, "R7 still received", d, 8'h6E);
        cfg_loop = 1'b0; idle(5);
    endtask

    task automatic t_rts;
        cfg_flow_en = 1'b1; cfg_tx_grace = 4'd2; rts_n = 1'b1;
        repeat (10) @(negedge clk);
        mon_cnt = 0;
        for (int i = 0; i < 4; i++) push(8'hB0 + 8'(i));
        repeat (1200) @(negedge clk);
        chk(mon_cnt == 2, "R8 grace of two", mon_cnt, 2);
        chk(tx_empty == 1'b0, "R9 queued bytes not empty", tx_empty, 0);
        rts_n = 1'b0;
        repeat (800) @(negedge clk);
        chk(mon_cnt == 4 && mon_byte[3] == 8'hB3, "R8 resume after rts low", mon_cnt, 4);
        cfg_tx_grace = 4'd0; rts_n = 1'b1;
        repeat (10) @(negedge clk);
        mon_cnt = 0;
        for (int i = 0; i < 4; i++) push(8'hC0 + 8'(i));
        @(negedge clk);
        chk(tx_ready == 1'b0, "R11 tx fifo full", tx_ready, 0);
        repeat (400) @(negedge clk);
        chk(mon_cnt == 0, "R8 zero grace stops at once", mon_cnt, 0);
        rts_n = 1'b0;
        repeat (1400) @(negedge clk);
        chk(mon_cnt == 4 && mon_byte[0] == 8'hC0, "R8 drain after release", mon_cnt, 4);
        chk(tx_empty == 1'b1, "R9 empty after drain", tx_empty, 1);
        cfg_flow_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1; bad = bad + 1;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_tx_basic;
        t_tx_narrow_parity;
        t_tx_stop0;
        t_rx_basic;
        t_rx_narrow_stop0;
        t_rx_parity;
        t_cts;
        t_loop;
        t_rts;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule